// File: doc/BRIEF.md
# Prioritized Interrupt Controller for an 8-bit Core

This block collects interrupt requests for a small 8-bit processor core and decides when the core must divert into a service routine. Each of eleven request inputs (timer, serial and external lines) sets a request flag. Per-source enables, a global enable and a two-bit priority level per source then decide which flag may cause a call. When the core signals that its current instruction may be interrupted, the block raises a one-cycle forced-call request. The request carries the fixed vector address of the winning source.

The block records which priority levels are in service, one bit per level. A running routine can only be preempted by a strictly higher level. A return-from-interrupt pulse from the core releases the highest level in service. No call is accepted while a return is executing, nor in the cycle after it. The same holds for a write to an enable or priority register. This gives software one instruction of grace after changing the configuration. An 8-bit register port gives read and write access to enables, priorities and flags.

Each source is built as either an edge-type or a level-type source. Edge-type flags clear themselves when their call is accepted. Level-type flags stay set until software clears them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request flag is set by its source whether or not the source or the global enable is on. Flags read back at address 6 (bit i = source i, sources 0..7) and address 7 (bit i-8 = source i, sources 8..10).
- R2: An edge-type source sets its flag on a 0-to-1 transition of its input. A level-type source sets its flag in every cycle its input is high. By default source 4 is level-type and all others are edge-type.
- R3: A flag can only cause a call when the global enable (address 0 bit 7) and the source's own enable are 1. Source enables are address 0 bits 4..0 for sources 0..4 and address 1 bits 5..0 for sources 5..10.
- R4: The level of source i is {high bit, low bit}. The low bit comes from address 2 (sources 0..7) or address 3 (bits 2..0, sources 8..10). The high bit comes from addresses 4 and 5 with the same layout. Level 3 is highest, and the highest pending level wins.
- R5: Among pending sources at the same level, the lowest source index wins.
- R6: An accepted call shows as call_req high for the cycle after the deciding clock edge, with call_vec = 3 + 8 × source index.
- R7: No call is accepted unless the winner's level is strictly above every level currently in service.
- R8: A return pulse clears the highest in-service level. No call is accepted in the cycle of the return or in the cycle after it.
- R9: A write to addresses 0..5 blocks acceptance in the cycle of the write and in the cycle after it. Writes to addresses 6..7 do not block.
- R10: No call is accepted while ack_window is low.
- R11: Accepting an edge-type source clears its flag. A level-type flag survives acceptance. Writing 0 to a flag bit at address 6 or 7 clears it, writing 1 leaves it unchanged, and a set in the same cycle wins.
- R12: After reset all registers read 0, no level is in service, and call_req is low.
- R13: Address 0 bit 6 is stored and read back with no effect on interrupts. Address 0 bit 5 always reads 0. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Request inputs, one per source |
| ack_window | input | 1 | Current instruction may be interrupted |
| reti | input | 1 | Current instruction is a return-from-interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0..7) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| call_req | output | 1 | Forced-call request, one cycle per accepted interrupt |
| call_vec | output | ADDR_W | Vector address, valid while call_req is high |

## Verification
The in-service mask is visible only through the calls it blocks or allows. If it is left set or cleared wrongly, a later request at that level is lost or accepted early. That shows at call_req within two cycles of the next request or return. A wrong flag or register bit shows on reg_rdata in the same cycle it is addressed, and at call_req or call_vec two edges after the source pulse that should have been taken. The bench keeps a cycle-by-cycle reference of flags, enables, levels and in-service state. Every cycle it compares call_req, call_vec and the addressed register against that reference, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int REG_W    = 8;
   localparam int RADDR_W  = 3;
   localparam int NUM_LVL  = 4;
   localparam int LVL_W    = 2;
   localparam int EN0_SRC  = 5;
   localparam int MAX_SRC  = EN0_SRC + REG_W;
   localparam int GLOB_BIT = 7;
   localparam int SPARE_BIT = 6;

   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic [RADDR_W-1:0] {
      RA_EN0  = 3'd0,
      RA_EN1  = 3'd1,
      RA_PRL0 = 3'd2,
      RA_PRL1 = 3'd3,
      RA_PRH0 = 3'd4,
      RA_PRH1 = 3'd5,
      RA_FLG0 = 3'd6,
      RA_FLG1 = 3'd7
   } reg_addr_e;

   function automatic logic is_cfg_addr(input logic [RADDR_W-1:0] a);
      return a <= RA_PRH1;
   endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [RADDR_W-1:0]   addr,
   input  logic [REG_W-1:0]     wdata,
   input  logic [NUM_SRC-1:0]   flags,
   output logic [REG_W-1:0]     rdata,
   output logic [NUM_SRC-1:0]   src_en,
   output logic                 glob_en,
   output logic [NUM_SRC-1:0]   prl,
   output logic [NUM_SRC-1:0]   prh,
   output logic                 cfg_wr,
   output logic [NUM_SRC-1:0]   flg_clr
);
   localparam int PAIR_W = 2 * REG_W;

   logic                 spare_q;
   logic [MAX_SRC-1:0]   en_wbits;
   logic [PAIR_W-1:0]    pair_wbits;
   logic [MAX_SRC-1:0]   en_pad;
   logic [PAIR_W-1:0]    prl_pad, prh_pad, flg_pad;

   assign en_wbits   = {wdata, wdata[EN0_SRC-1:0]};
   assign pair_wbits = {wdata, wdata};
   assign cfg_wr     = wr && is_cfg_addr(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         spare_q <= 1'b0;
         src_en  <= '0;
         prl     <= '0;
         prh     <= '0;
      end else if (wr) begin
         if (addr == RA_EN0) begin
            glob_en <= wdata[GLOB_BIT];
            spare_q <= wdata[SPARE_BIT];
         end
         for (int i = 0; i < NUM_SRC; i++) begin
            if (i < EN0_SRC) begin
               if (addr == RA_EN0) src_en[i] <= en_wbits[i];
            end else begin
               if (addr == RA_EN1) src_en[i] <= en_wbits[i];
            end
            if (i < REG_W) begin
               if (addr == RA_PRL0) prl[i] <= pair_wbits[i];
               if (addr == RA_PRH0) prh[i] <= pair_wbits[i];
            end else begin
               if (addr == RA_PRL1) prl[i] <= pair_wbits[i];
               if (addr == RA_PRH1) prh[i] <= pair_wbits[i];
            end
         end
      end
   end

   // software clear: a 0 written to a flag bit clears it
   always_comb begin
      flg_clr = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (i < REG_W)
            flg_clr[i] = wr && (addr == RA_FLG0) && !pair_wbits[i];
         else
            flg_clr[i] = wr && (addr == RA_FLG1) && !pair_wbits[i];
      end
   end

   assign en_pad  = MAX_SRC'(src_en);
   assign prl_pad = PAIR_W'(prl);
   assign prh_pad = PAIR_W'(prh);
   assign flg_pad = PAIR_W'(flags);

   always_comb begin
      unique case (addr)
         RA_EN0:  rdata = {glob_en, spare_q, 1'b0, en_pad[EN0_SRC-1:0]};
         RA_EN1:  rdata = en_pad[MAX_SRC-1:EN0_SRC];
         RA_PRL0: rdata = prl_pad[REG_W-1:0];
         RA_PRL1: rdata = prl_pad[PAIR_W-1:REG_W];
         RA_PRH0: rdata = prh_pad[REG_W-1:0];
         RA_PRH1: rdata = prh_pad[PAIR_W-1:REG_W];
         RA_FLG0: rdata = flg_pad[REG_W-1:0];
         default: rdata = flg_pad[PAIR_W-1:REG_W];
      endcase
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int                 NUM_SRC    = 11,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] sw_clr,
   input  logic [NUM_SRC-1:0] ack_clr,
   output logic [NUM_SRC-1:0] flags
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic set_now;
      logic clr_now;
      if (LEVEL_MASK[i]) begin : g_level
         assign set_now = src_req[i];
         assign clr_now = sw_clr[i];
      end else begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_req[i];
         end
         assign set_now = src_req[i] && !prev_q;
         assign clr_now = sw_clr[i] || ack_clr[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[i] <= 1'b0;
         else if (set_now) flags[i] <= 1'b1;
         else if (clr_now) flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int NUM_SRC   = 11,
   parameter int ARB_STYLE = 0,
   localparam int IDX_W    = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] prl,
   input  logic [NUM_SRC-1:0] prh,
   output logic               win_valid,
   output lvl_t               win_lvl,
   output logic [IDX_W-1:0]   win_idx
);
   lvl_t src_lvl [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
      assign src_lvl[i] = {prh[i], prl[i]};
   end

   if (ARB_STYLE == 0) begin : g_scan
      // one pass from the top index down; >= lets the lower index take ties
      always_comb begin
         win_valid = 1'b0;
         win_lvl   = '0;
         win_idx   = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!win_valid || src_lvl[i] >= win_lvl)) begin
               win_valid = 1'b1;
               win_lvl   = src_lvl[i];
               win_idx   = IDX_W'(i);
            end
         end
      end
   end else begin : g_by_level
      // per-level request vectors, then a priority pick inside the top level
      logic [NUM_SRC-1:0] hit [NUM_LVL];
      logic [NUM_SRC-1:0] sel_hit;
      always_comb begin
         for (int l = 0; l < NUM_LVL; l++)
            for (int i = 0; i < NUM_SRC; i++)
               hit[l][i] = pend[i] && (src_lvl[i] == lvl_t'(l));
      end
      always_comb begin
         win_valid = 1'b0;
         win_lvl   = '0;
         sel_hit   = '0;
         for (int l = 0; l < NUM_LVL; l++) begin
            if (|hit[l]) begin
               win_valid = 1'b1;
               win_lvl   = lvl_t'(l);
               sel_hit   = hit[l];
            end
         end
         win_idx = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--)
            if (sel_hit[i]) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
   import irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  lvl_t               push_lvl,
   input  logic               pop,
   output logic [NUM_LVL-1:0] isr_mask,
   output logic               top_valid,
   output lvl_t               top_lvl
);
   always_comb begin
      top_valid = 1'b0;
      top_lvl   = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (isr_mask[l]) begin
            top_valid = 1'b1;
            top_lvl   = lvl_t'(l);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         isr_mask <= '0;
      else if (push)
         isr_mask[push_lvl] <= 1'b1;
      else if (pop && top_valid)
         isr_mask[top_lvl] <= 1'b0;
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int                 NUM_SRC    = 11,
   parameter int                 ADDR_W     = 16,
   parameter int                 VEC_BASE   = 3,
   parameter int                 VEC_STEP   = 8,
   parameter logic [NUM_SRC-1:0] LEVEL_MASK = 11'b000_0001_0000,
   parameter int                 ARB_STYLE  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_req,
   input  logic                ack_window,
   input  logic                reti,
   input  logic                reg_wr,
   input  logic [RADDR_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                call_req,
   output logic [ADDR_W-1:0]   call_vec
);
   localparam int IDX_W = $clog2(NUM_SRC);
   localparam longint VEC_LAST = longint'(VEC_BASE) + longint'(VEC_STEP) * (NUM_SRC - 1);

   if (NUM_SRC < 2 || NUM_SRC > MAX_SRC) begin : g_bad_nsrc
      $error("irq_prio_ctrl: NUM_SRC must lie in 2..%0d", MAX_SRC);
   end
   if (VEC_STEP < 1 || VEC_BASE < 0) begin : g_bad_vec
      $error("irq_prio_ctrl: VEC_STEP must be positive and VEC_BASE non-negative");
   end
   if (VEC_LAST >= (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("irq_prio_ctrl: ADDR_W too narrow for the last vector");
   end
   if (ARB_STYLE != 0 && ARB_STYLE != 1) begin : g_bad_arb
      $error("irq_prio_ctrl: ARB_STYLE must be 0 or 1");
   end

   logic [NUM_SRC-1:0] flags, src_en, prl, prh, flg_clr, ack_clr, pend;
   logic               glob_en, cfg_wr, blk_q, accept;
   logic               win_valid, top_valid;
   lvl_t               win_lvl, top_lvl;
   logic [IDX_W-1:0]   win_idx;
   logic [NUM_LVL-1:0] isr_mask;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .flags   (flags),
      .rdata   (reg_rdata),
      .src_en  (src_en),
      .glob_en (glob_en),
      .prl     (prl),
      .prh     (prh),
      .cfg_wr  (cfg_wr),
      .flg_clr (flg_clr)
   );

   irq_flag_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_req (src_req),
      .sw_clr  (flg_clr),
      .ack_clr (ack_clr),
      .flags   (flags)
   );

   assign pend = flags & src_en;

   irq_arbiter #(.NUM_SRC(NUM_SRC), .ARB_STYLE(ARB_STYLE)) u_arb (
      .pend      (pend),
      .prl       (prl),
      .prh       (prh),
      .win_valid (win_valid),
      .win_lvl   (win_lvl),
      .win_idx   (win_idx)
   );

   irq_svc_track u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_lvl  (win_lvl),
      .pop       (reti),
      .isr_mask  (isr_mask),
      .top_valid (top_valid),
      .top_lvl   (top_lvl)
   );

   // one instruction of grace after a return or a configuration write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_q <= 1'b0;
      else        blk_q <= reti || cfg_wr;
   end

   assign accept = win_valid && glob_en && ack_window && !reti && !cfg_wr && !blk_q
                   && (!top_valid || (win_lvl > top_lvl));

   assign ack_clr = accept ? (NUM_SRC'(1) << win_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         call_req <= 1'b0;
         call_vec <= '0;
      end else begin
         call_req <= accept;
         if (accept)
            call_vec <= ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
      end
   end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
   import irq_pkg::*;
#(
   parameter int NUM_SRC  = 11,
   parameter int ADDR_W   = 16,
   parameter int VEC_BASE = 3,
   parameter int VEC_STEP = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack_window,
   input logic               reti,
   input logic               reg_wr,
   input logic [RADDR_W-1:0] reg_addr,
   input logic               call_req,
   input logic [ADDR_W-1:0]  call_vec,
   input logic [NUM_LVL-1:0] isr_mask,
   input logic               glob_en
);
   logic reti_d, cfg_d, cfg_now;

   assign cfg_now = reg_wr && (reg_addr <= RA_PRH1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reti_d <= 1'b0;
         cfg_d  <= 1'b0;
      end else begin
         reti_d <= reti;
         cfg_d  <= cfg_now;
      end
   end

   assert_no_call_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !call_req);

   assert_vec_on_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> (int'(call_vec) >= VEC_BASE)
                && (((int'(call_vec) - VEC_BASE) % VEC_STEP) == 0)
                && (((int'(call_vec) - VEC_BASE) / VEC_STEP) < NUM_SRC));

   assert_call_pushes_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> ($countones(isr_mask) == $countones($past(isr_mask)) + 1));

   assert_reti_pops_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && (isr_mask != '0)) |=> ($countones(isr_mask) + 1 == $countones($past(isr_mask))));

   assert_reti_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti || reti_d) |=> !call_req);

   assert_cfg_write_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_now || cfg_d) |=> !call_req);

   assert_window_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_window |=> !call_req);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NUM_SRC  (NUM_SRC),
   .ADDR_W   (ADDR_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_window (ack_window),
   .reti       (reti),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .call_req   (call_req),
   .call_vec   (call_vec),
   .isr_mask   (isr_mask),
   .glob_en    (glob_en)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 11;
   localparam logic [NSRC-1:0] LVLM = 11'b000_0001_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_req = '0;
   logic            ack_window = 1'b0, reti = 1'b0, reg_wr = 1'b0;
   logic [2:0]      reg_addr = '0;
   logic [7:0]      reg_wdata = '0;
   logic [7:0]      reg_rdata;
   logic            call_req;
   logic [15:0]     call_vec;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack_window(ack_window),
      .reti(reti), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .call_req(call_req), .call_vec(call_vec)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   // reference state, updated from the requirements
   logic [NSRC-1:0] m_flag = '0, m_en = '0, m_prl = '0, m_prh = '0, m_prev = '0;
   logic            m_glob = 0, m_spare = 0, m_blk = 0;
   logic [3:0]      m_isr = '0;
   logic            e_call;
   logic [15:0]     e_vec;
   string           e_tag;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [2:0] a);
      logic [15:0] p;
      case (a)
         3'd0: return {m_glob, m_spare, 1'b0, m_en[4:0]};
         3'd1: return {2'b00, m_en[10:5]};
         3'd2, 3'd3: p = 16'(m_prl);
         3'd4, 3'd5: p = 16'(m_prh);
         default: p = 16'(m_flag);
      endcase
      return a[0] ? p[15:8] : p[7:0];
   endfunction

   // one clock: check the addressed register, predict, clock, check the call
   task automatic tick();
      logic [NSRC-1:0] pend, set, swc, ackc;
      logic [15:0] wb;
      int w, top;
      logic [1:0] wl, lv;
      logic cfg;
      #1;
      chk(reg_rdata, m_read(reg_addr), (reg_addr >= 6) ? "R1 R2 R11 flags" : "R4 R13 regs", "reg_rdata");
      pend = m_flag & m_en;
      w = -1; wl = 0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         lv = {m_prh[i], m_prl[i]};
         if (pend[i] && (w < 0 || lv >= wl)) begin w = i; wl = lv; end
      end
      top = -1;
      for (int l = 0; l < 4; l++) if (m_isr[l]) top = l;
      cfg = reg_wr && (reg_addr <= 3'd5);
      e_call = 0;
      if (w < 0 || !m_glob)        e_tag = "R3";
      else if (reti || m_blk)      e_tag = "R8 R9 block";
      else if (cfg)                e_tag = "R9";
      else if (!ack_window)        e_tag = "R10";
      else if (top >= int'(wl))    e_tag = "R7";
      else begin e_call = 1; e_tag = "R6"; e_vec = 16'(3 + 8 * w); end
      // next state
      set = (src_req & LVLM) | (src_req & ~m_prev & ~LVLM);
      wb = {reg_wdata, reg_wdata};
      swc = '0;
      if (reg_wr && reg_addr == 3'd6) swc = ~NSRC'(wb[7:0]) & NSRC'(8'hFF);
      if (reg_wr && reg_addr == 3'd7) swc = ~(NSRC'(wb[15:8]) << 8) & (NSRC'(7) << 8);
      ackc = (e_call && !LVLM[w]) ? (NSRC'(1) << w) : '0;
      m_flag = set | (m_flag & ~swc & ~ackc);
      if (e_call) m_isr[wl] = 1'b1;
      else if (reti && top >= 0) m_isr[top] = 1'b0;
      m_blk = reti || cfg;
      m_prev = src_req;
      if (reg_wr) begin
         case (reg_addr)
            3'd0: begin m_glob = reg_wdata[7]; m_spare = reg_wdata[6]; m_en[4:0] = reg_wdata[4:0]; end
            3'd1: m_en[10:5] = reg_wdata[5:0];
            3'd2: m_prl[7:0] = reg_wdata;
            3'd3: m_prl[10:8] = reg_wdata[2:0];
            3'd4: m_prh[7:0] = reg_wdata;
            3'd5: m_prh[10:8] = reg_wdata[2:0];
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      chk(call_req, e_call, e_tag, "call_req");
      if (e_call) chk(call_vec, e_vec, "R4 R5 R6", "call_vec");
   endtask

   task automatic cyc(input logic [NSRC-1:0] s, input logic aw, input logic rt,
                      input logic w, input logic [2:0] a, input logic [7:0] d);
      src_req = s; ack_window = aw; reti = rt; reg_wr = w; reg_addr = a; reg_wdata = d;
      tick();
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         report();
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12: reset state
      #1;
      chk(call_req, 0, "R12", "call_req after reset");
      for (int a = 0; a < 8; a++) begin
         reg_addr = 3'(a); #1;
         chk(reg_rdata, 0, "R12", "register after reset");
      end
      @(negedge clk);
      // R13: spare bit stored, bit 5 reads 0
      cyc('0, 0, 0, 1, 3'd0, 8'hFF);
      cyc('0, 0, 0, 0, 3'd0, 8'h00);
      chk(m_read(3'd0), 8'hDF, "R13", "reference layout");
      // R1 R3: global off, flag still latches, no call
      cyc('0, 1, 0, 1, 3'd0, 8'h1F);
      cyc(11'h001, 1, 0, 0, 3'd6, 0);
      cyc('0, 1, 0, 0, 3'd6, 0);
      cyc('0, 1, 0, 0, 3'd6, 0);
      // R9 then R6: enabling globally blocks two cycles, then vector 3
      cyc('0, 1, 0, 1, 3'd0, 8'h9F);
      repeat (3) cyc('0, 1, 0, 0, 3'd6, 0);
      // R10 then R7: source 3 waits on window, then on level 0 in service
      cyc(11'h008, 0, 0, 0, 3'd6, 0);
      repeat (2) cyc('0, 0, 0, 0, 3'd6, 0);
      repeat (2) cyc('0, 1, 0, 0, 3'd6, 0);
      // R8: return releases level 0, blocked two cycles, then source 3
      cyc('0, 1, 1, 0, 3'd6, 0);
      repeat (3) cyc('0, 1, 0, 0, 3'd6, 0);
      cyc('0, 1, 1, 0, 3'd6, 0);
      // R4: source 2 at level 3, source 1 at level 1
      cyc('0, 1, 0, 1, 3'd2, 8'h06);
      cyc('0, 1, 0, 1, 3'd4, 8'h04);
      cyc('0, 1, 0, 1, 3'd1, 8'h3F);
      cyc(11'h006, 1, 0, 0, 3'd2, 0);
      repeat (3) cyc('0, 1, 0, 0, 3'd4, 0);
      cyc('0, 1, 1, 0, 3'd6, 0);
      repeat (3) cyc('0, 1, 0, 0, 3'd6, 0);
      // R7: level 1 in service; level 0 waits, level 3 preempts
      cyc(11'h001, 1, 0, 0, 3'd6, 0);
      cyc(11'h004, 1, 0, 0, 3'd6, 0);
      repeat (3) cyc('0, 1, 0, 0, 3'd6, 0);
      repeat (3) begin
         cyc('0, 1, 1, 0, 3'd6, 0);
         cyc('0, 1, 0, 0, 3'd6, 0);
         cyc('0, 1, 0, 0, 3'd6, 0);
      end
      // R5: sources 0 and 3 both level 0, lowest index first
      cyc('0, 1, 0, 1, 3'd2, 8'h00);
      cyc('0, 1, 0, 1, 3'd4, 8'h00);
      cyc(11'h009, 0, 0, 0, 3'd6, 0);
      repeat (3) cyc('0, 1, 0, 0, 3'd6, 0);
      cyc('0, 1, 1, 0, 3'd6, 0);
      repeat (3) cyc('0, 1, 0, 0, 3'd6, 0);
      cyc('0, 1, 1, 0, 3'd6, 0);
      repeat (2) cyc('0, 1, 0, 0, 3'd6, 0);
      // R2 R11: level source 4 keeps its flag after acceptance; software clears it
      repeat (3) cyc(11'h010, 1, 0, 0, 3'd6, 0);
      repeat (2) cyc('0, 1, 0, 0, 3'd6, 0);
      cyc('0, 1, 0, 1, 3'd6, 8'hEF);
      cyc('0, 1, 1, 0, 3'd6, 0);
      repeat (2) cyc('0, 1, 0, 0, 3'd6, 0);
      // constrained random traffic
      for (int n = 0; n < 6000; n++) begin
         logic [NSRC-1:0] s;
         logic w;
         s = NSRC'($urandom & $urandom & $urandom);
         w = ($urandom_range(0, 9) == 0);
         cyc(s, $urandom_range(0, 4) != 0, $urandom_range(0, 5) == 0, w,
             3'($urandom_range(0, 7)), 8'($urandom));
      end
      done = 1;
      report();
   end
endmodule